// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Controller

This block gates the start of each frame on a shared-medium Ethernet transmit path. A frame request is held pending until the inter-frame gap is met and any back-off wait has run out. The block then raises transmit-enable until the frame completes or a collision ends the attempt.

After a good frame, the gap is timed from the end of that frame, and carrier sense is ignored. After a collision or a drop, the gap counter is held at zero while carrier sense is high, so the gap is timed from the moment the carrier goes away. A collision inside the first slot of the frame is answered with a jam request. The controller then draws a back-off delay from a free-running LFSR, masked to the current exponent, and retries. A collision after the first slot, or the final permitted collision, drops the frame.

In full-duplex mode the collision input is ignored and no back-off is applied. The gap is still enforced. All timing advances only on the bit-time tick input.

Top module: `hd_tx_retry_ctrl`

## Requirements
- R1: After a frame ends with the done strobe, transmit-enable stays low for at least GAP_BITS bit ticks. With a tick on every cycle, it rises exactly GAP_BITS+1 cycles after the done edge when a request is waiting. Carrier sense has no effect on this gap.
- R2: After a collision or a drop, the gap counter is held at zero while carrier sense is high. With a tick on every cycle, transmit-enable rises exactly GAP_BITS+1 cycles after carrier sense falls, provided back-off has ended.
- R3: A half-duplex collision seen while transmitting, with the bit count below SLOT_BITS and fewer than MAX_ATTEMPTS-1 earlier collisions, has these effects on the next cycle:
  - the collision counter increments;
  - the retry output pulses for one cycle;
  - transmit-enable drops.
- R4: Every collision inside the slot window, including the final one, raises the jam output for exactly JAM_BITS bit ticks, starting the cycle after the collision.
- R5: After the n-th collision, the back-off wait is k*SLOT_BITS bit ticks, with k between 0 and 2^min(n,BACKOFF_LIMIT)-1. k is taken from the low bits of a free-running 16-bit LFSR, so successive draws differ.
- R6: The collision that brings the count to MAX_ATTEMPTS pulses the drop output instead of the retry output. No further attempt of that frame is made.
- R7: A collision with the bit count at or above SLOT_BITS is late. On the next cycle it pulses the drop output, with no jam and no retry, and the frame is not retried. A bit count of SLOT_BITS-1 is still inside the window.
- R8: With full duplex selected, the collision input has no effect: there is no jam, no retry and no drop, and the counter stays at 0. The gap of R1 still applies.
- R9: A successful frame or a drop clears the collision counter to 0.
- R10: After reset, every output is low and the collision counter is 0. The gap counts as already met, so a first request raises transmit-enable two cycles after the strobe.
- R11: A request strobe that arrives while a frame is pending is ignored: no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One pulse per bit time |
| full_duplex_i | input | 1 | 1 selects full duplex |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detect |
| req_i | input | 1 | Frame request strobe |
| tx_done_i | input | 1 | Current frame sent without collision |
| bit_cnt_i | input | BITCNT_W | Bits sent so far in the current frame |
| tx_en_o | output | 1 | Frame may be transmitted |
| retry_o | output | 1 | One-cycle pulse: frame will be retried |
| drop_o | output | 1 | One-cycle pulse: frame dropped |
| jam_o | output | 1 | Jam request, JAM_BITS ticks long |
| col_cnt_o | output | $clog2(MAX_ATTEMPTS+1) | Collisions of the current frame |

## Verification
Several properties are checked by assertions on every cycle:
- the mutual exclusion of retry and drop, and of transmit-enable and jam;
- that the counter stays below its limit and rises by one with each retry;
- that a late collision leads to a drop with no jam;
- that full duplex suppresses all collision reactions;
- that each drawn back-off fits its mask.

Only the bench scenarios can show the exact gap lengths counted from end of frame versus from carrier fall, the jam duration, and that measured back-off waits are whole slot multiples within the exponent range. They also show the 16-collision sequence and that a dropped frame never restarts.

// File: rtl/hdtx_pkg.sv
`timescale 1ns/1ps
package hdtx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_JAM, ST_BACKOFF} hdtx_state_e;

  // maximal-length Galois feedback masks per register width
  function automatic logic [31:0] lfsr_taps(input int w);
    case (w)
      8:       return 32'h0000_00B8;
      16:      return 32'h0000_B400;
      24:      return 32'h00E1_0000;
      default: return 32'hA300_0000;
    endcase
  endfunction
endpackage

// File: rtl/hdtx_lfsr.sv
`timescale 1ns/1ps
module hdtx_lfsr import hdtx_pkg::*; #(
  parameter int           W     = 16,
  parameter int           OUT_W = 10,
  parameter logic [W-1:0] SEED  = W'(16'hACE1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign rnd_o = state_q[OUT_W-1:0];

  p_lfsr_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/hdtx_gap_timer.sv
`timescale 1ns/1ps
module hdtx_gap_timer #(
  parameter int GAP_BITS = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic ok_o
);
  localparam int GAP_W = $clog2(GAP_BITS + 1);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= GAP_W'(GAP_BITS);
    else if (clear_i)                               cnt_q <= '0;
    else if (tick_i && cnt_q != GAP_W'(GAP_BITS))   cnt_q <= cnt_q + GAP_W'(1);
  end

  assign ok_o = (cnt_q == GAP_W'(GAP_BITS));

  p_gap_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= GAP_W'(GAP_BITS));
  p_gap_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ok_o);
endmodule

// File: rtl/hdtx_backoff.sv
`timescale 1ns/1ps
module hdtx_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int LIMIT     = 10,
  parameter int CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] attempt_i,
  input  logic [LIMIT-1:0] rnd_i,
  output logic             busy_o
);
  localparam int SLOT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  logic [LIMIT-1:0]  mask;
  logic [LIMIT-1:0]  slots_q;
  logic [SLOT_W-1:0] tick_q;

  // exponent = min(attempt, LIMIT): bit i enabled when attempt > i
  always_comb begin
    for (int i = 0; i < LIMIT; i++) mask[i] = (int'(attempt_i) > i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      tick_q  <= '0;
    end else if (load_i) begin
      slots_q <= rnd_i & mask;
      tick_q  <= '0;
    end else if (slots_q != '0 && tick_i) begin
      if (tick_q == SLOT_W'(SLOT_BITS - 1)) begin
        tick_q  <= '0;
        slots_q <= slots_q - LIMIT'(1);
      end else begin
        tick_q  <= tick_q + SLOT_W'(1);
      end
    end
  end

  assign busy_o = (slots_q != '0);

  p_slots_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (slots_q & ~$past(mask)) == '0);
endmodule

// File: rtl/hd_tx_retry_ctrl.sv
`timescale 1ns/1ps
module hd_tx_retry_ctrl import hdtx_pkg::*; #(
  parameter int                GAP_BITS      = 96,
  parameter int                SLOT_BITS     = 512,
  parameter int                JAM_BITS      = 32,
  parameter int                MAX_ATTEMPTS  = 16,
  parameter int                BACKOFF_LIMIT = 10,
  parameter int                BITCNT_W      = 16,
  parameter int                LFSR_W        = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED     = LFSR_W'(16'hACE1)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  bit_tick_i,
  input  logic                                  full_duplex_i,
  input  logic                                  crs_i,
  input  logic                                  col_i,
  input  logic                                  req_i,
  input  logic                                  tx_done_i,
  input  logic [BITCNT_W-1:0]                   bit_cnt_i,
  output logic                                  tx_en_o,
  output logic                                  retry_o,
  output logic                                  drop_o,
  output logic                                  jam_o,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0]     col_cnt_o
);
  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int JAM_W = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;

  hdtx_state_e       state_q;
  logic              pending_q, from_crs_q, retry_q, drop_q;
  logic [CNT_W-1:0]  col_cnt_q, col_next;
  logic [JAM_W-1:0]  jam_cnt_q;
  logic              collide, late, final_hit, jam_done, gap_clear, gap_ok, bo_load, bo_busy;
  logic [BACKOFF_LIMIT-1:0] rnd;

  assign collide   = (state_q == ST_TX) && col_i && !full_duplex_i;
  assign late      = bit_cnt_i >= BITCNT_W'(SLOT_BITS);
  assign col_next  = col_cnt_q + CNT_W'(1);
  assign final_hit = (col_next == CNT_W'(MAX_ATTEMPTS));
  assign jam_done  = (state_q == ST_JAM) && bit_tick_i && (jam_cnt_q == JAM_W'(JAM_BITS - 1));
  // after a good frame the gap runs from frame end; after a collision it restarts on carrier
  assign gap_clear = (state_q == ST_TX) || (state_q == ST_JAM) || (from_crs_q && crs_i);
  assign bo_load   = jam_done && pending_q;

  hdtx_lfsr #(.W(LFSR_W), .OUT_W(BACKOFF_LIMIT), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i, .rst_ni, .rnd_o(rnd)
  );

  hdtx_gap_timer #(.GAP_BITS(GAP_BITS)) u_gap (
    .clk_i, .rst_ni, .tick_i(bit_tick_i), .clear_i(gap_clear), .ok_o(gap_ok)
  );

  hdtx_backoff #(.SLOT_BITS(SLOT_BITS), .LIMIT(BACKOFF_LIMIT), .CNT_W(CNT_W)) u_backoff (
    .clk_i, .rst_ni, .tick_i(bit_tick_i), .load_i(bo_load),
    .attempt_i(col_cnt_q), .rnd_i(rnd), .busy_o(bo_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pending_q  <= 1'b0;
      from_crs_q <= 1'b0;
      retry_q    <= 1'b0;
      drop_q     <= 1'b0;
      col_cnt_q  <= '0;
      jam_cnt_q  <= '0;
    end else begin
      retry_q <= 1'b0;
      drop_q  <= 1'b0;
      if (req_i && !pending_q) pending_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (pending_q && gap_ok) begin
            state_q    <= ST_TX;
            from_crs_q <= 1'b0;
          end
        end
        ST_TX: begin
          if (collide) begin
            from_crs_q <= 1'b1;
            jam_cnt_q  <= '0;
            if (late) begin
              drop_q    <= 1'b1;
              pending_q <= 1'b0;
              col_cnt_q <= '0;
              state_q   <= ST_IDLE;
            end else if (final_hit) begin
              drop_q    <= 1'b1;
              pending_q <= 1'b0;
              col_cnt_q <= '0;
              state_q   <= ST_JAM;
            end else begin
              retry_q   <= 1'b1;
              col_cnt_q <= col_next;
              state_q   <= ST_JAM;
            end
          end else if (tx_done_i) begin
            pending_q <= 1'b0;
            col_cnt_q <= '0;
            state_q   <= ST_IDLE;
          end
        end
        ST_JAM: begin
          if (jam_done)        state_q   <= pending_q ? ST_BACKOFF : ST_IDLE;
          else if (bit_tick_i) jam_cnt_q <= jam_cnt_q + JAM_W'(1);
        end
        ST_BACKOFF: begin
          if (!bo_busy) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_en_o   = (state_q == ST_TX);
  assign jam_o     = (state_q == ST_JAM);
  assign retry_o   = retry_q;
  assign drop_o    = drop_q;
  assign col_cnt_o = col_cnt_q;

  p_gap_before_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(gap_ok));
  p_retry_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (col_cnt_o == $past(col_cnt_o) + CNT_W'(1)) && jam_o);
  p_jam_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_cnt_q <= JAM_W'(JAM_BITS - 1));
  p_final_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide && !late && col_cnt_o == CNT_W'(MAX_ATTEMPTS - 1)) |=> drop_o && !retry_o && jam_o);
  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retry_o && drop_o) && !(tx_en_o && jam_o));
  p_late_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide && late) |=> drop_o && !jam_o && !retry_o && !tx_en_o);
  p_fd_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && full_duplex_i) |=> !retry_o && !drop_o && !jam_o);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o || (tx_en_o && tx_done_i && !collide)) |-> ##1 col_cnt_o == '0 || $past(drop_o));
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cnt_o < CNT_W'(MAX_ATTEMPTS));
endmodule

// File: tb/hd_tx_retry_ctrl_tb_top.sv
`timescale 1ns/1ps
module hd_tx_retry_ctrl_tb_top;
  localparam int GAP  = 6;
  localparam int SLOT = 8;
  localparam int JAM  = 3;
  localparam int MAXA = 16;
  localparam int LIM  = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_tick_i = 1'b1, full_duplex_i = 1'b0, crs_i = 1'b0, col_i = 1'b0;
  logic req_i = 1'b0, tx_done_i = 1'b0;
  logic [15:0] bit_cnt_i = '0;
  logic tx_en_o, retry_o, drop_o, jam_o;
  logic [4:0] col_cnt_o;

  int n_tests = 0, n_fail = 0, tick_per = 1;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  hd_tx_retry_ctrl #(
    .GAP_BITS(GAP), .SLOT_BITS(SLOT), .JAM_BITS(JAM),
    .MAX_ATTEMPTS(MAXA), .BACKOFF_LIMIT(LIM), .BITCNT_W(16)
  ) dut_i (
    .clk_i, .rst_ni, .bit_tick_i, .full_duplex_i, .crs_i, .col_i, .req_i,
    .tx_done_i, .bit_cnt_i, .tx_en_o, .retry_o, .drop_o, .jam_o, .col_cnt_o
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk_i);
      ph = (ph + 1) % tick_per;
      bit_tick_i = (ph == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic request_and_wait(output int n);
    req_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk_i);
      req_i = 1'b0;
      n++;
    end while (!tx_en_o && n < 5000);
  endtask

  task automatic end_frame();
    tx_done_i = 1'b1;
    @(negedge clk_i);
    tx_done_i = 1'b0;
  endtask

  task automatic wait_tx(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tx_en_o && n < 5000);
  endtask

  task automatic collide(input int bc, output logic r, output logic d, output logic j, output int c);
    bit_cnt_i = 16'(bc);
    col_i = 1'b1;
    @(negedge clk_i);
    col_i = 1'b0;
    r = retry_o; d = drop_o; j = jam_o; c = int'(col_cnt_o);
  endtask

  task automatic jam_len(output int len);
    len = 1;
    forever begin
      @(negedge clk_i);
      if (!jam_o || len > 100) break;
      len++;
    end
  endtask

  task automatic quiet(input int cyc, output int hits);
    hits = 0;
    repeat (cyc) begin
      @(negedge clk_i);
      if (tx_en_o) hits++;
    end
  endtask

  function automatic bit backoff_ok(input int n, input int c, output int k);
    int e = (c < LIM) ? c : LIM;
    k = 0;
    if (n == GAP + 1) return 1'b1;
    if (n < 2 || (n - 2) % SLOT != 0) return 1'b0;
    k = (n - 2) / SLOT;
    return (k >= 1) && (k <= (1 << e) - 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n, c, len, hits, k, kfirst, kdiff;
    logic r, d, j;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk(!tx_en_o && !retry_o && !drop_o && !jam_o, "R10 outputs idle after reset", int'(tx_en_o|retry_o|drop_o|jam_o), 0);
    chk(col_cnt_o == 0, "R10 counter after reset", int'(col_cnt_o), 0);
    request_and_wait(n);
    chk(n == 2, "R10 first start latency", n, 2);

    // R11 request while pending is ignored
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    end_frame();
    quiet(40, hits);
    chk(hits == 0, "R11 extra request ignored", hits, 0);

    // R1 gap after good frame, sweep tick period, carrier high is ignored
    for (int p = 1; p <= 3; p++) begin
      tick_per = p;
      request_and_wait(n);
      crs_i = 1'b1;
      end_frame();
      request_and_wait(n);
      crs_i = 1'b0;
      chk(n >= 2 + (GAP - 1) * p && n <= p * GAP + 1, $sformatf("R1 gap period %0d", p), n, p * GAP + 1);
      end_frame();
    end
    tick_per = 1;
    @(negedge clk_i);

    // R3 R4 R5 R6 collision sequence up to the limit
    request_and_wait(n);
    kfirst = -1;
    kdiff = 0;
    for (int ci = 1; ci <= MAXA; ci++) begin
      collide((ci == 1) ? SLOT - 1 : (ci * 3) % SLOT, r, d, j, c);
      if (ci < MAXA) begin
        chk(r && !d, $sformatf("R3 retry pulse at collision %0d", ci), int'(r), 1);
        chk(c == ci, "R3 counter increments", c, ci);
        chk(j, "R4 jam raised", int'(j), 1);
        jam_len(len);
        chk(len == JAM, "R4 jam length", len, JAM);
        wait_tx(n);
        chk(backoff_ok(n, ci, k), $sformatf("R5 back-off wait after collision %0d", ci), n, GAP + 1);
        if (ci >= LIM) begin
          if (kfirst < 0) kfirst = k;
          else if (k != kfirst) kdiff++;
        end
      end else begin
        chk(d && !r, "R6 drop on final collision", int'(d), 1);
        chk(c == 0, "R9 counter cleared on drop", c, 0);
        jam_len(len);
        chk(len == JAM, "R4 jam length on final collision", len, JAM);
        quiet(300, hits);
        chk(hits == 0, "R6 dropped frame not restarted", hits, 0);
      end
    end
    chk(kdiff > 0, "R5 back-off draws vary", kdiff, 1);

    // R7 late collision, after one in-window collision
    request_and_wait(n);
    collide(0, r, d, j, c);
    chk(c == 1 && r, "R3 in-window collision before late test", c, 1);
    jam_len(len);
    wait_tx(n);
    collide(SLOT, r, d, j, c);
    chk(d && !r && !j && !tx_en_o, "R7 late collision drops without jam", int'({d, r, j}), 4);
    chk(c == 0, "R9 counter cleared by late drop", c, 0);
    quiet(100, hits);
    chk(hits == 0, "R7 no retry after late collision", hits, 0);

    // R2 gap timed from carrier fall after a collision
    request_and_wait(n);
    crs_i = 1'b1;
    collide(2, r, d, j, c);
    quiet(300, hits);
    chk(hits == 0, "R2 held off while carrier high", hits, 0);
    crs_i = 1'b0;
    wait_tx(n);
    chk(n == GAP + 1, "R2 gap from carrier fall", n, GAP + 1);
    end_frame();
    chk(col_cnt_o == 0, "R9 counter cleared on success", int'(col_cnt_o), 0);

    // R8 full duplex ignores collisions but keeps the gap
    full_duplex_i = 1'b1;
    request_and_wait(n);
    hits = 0;
    repeat (5) begin
      col_i = 1'b1;
      crs_i = 1'b1;
      @(negedge clk_i);
      if (!tx_en_o || jam_o || retry_o || drop_o || col_cnt_o != 0) hits++;
    end
    col_i = 1'b0;
    crs_i = 1'b0;
    chk(hits == 0, "R8 collision ignored in full duplex", hits, 0);
    end_frame();
    request_and_wait(n);
    chk(n == GAP + 1, "R8 gap kept in full duplex", n, GAP + 1);
    end_frame();
    full_duplex_i = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule